// File: doc/BRIEF.md
# Split-Transaction Memory Target

This block is a small memory that sits on a shared, synchronous broadcast bus. Every cycle it samples the request lines. It keeps only messages whose address falls inside its own power-of-two window, which it recognises from the upper address bits alone. A write stores its payload and is acknowledged. A read is acknowledged at once, so the requester can leave the bus. The target then reads its internal array and counts out a fixed two-cycle latency. After that it asks an external arbiter for the bus.

Once granted, the target broadcasts a reply that pairs the requester's identifier with the value read. It holds the reply until the requester acknowledges it. Only one read can be in flight. Reads that arrive while a reply is pending get no acknowledgement and are dropped. Writes continue to be accepted during that time.

Top module: `split_mem_target`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req_ack`, `bus_req` and `reply_valid` are low. Every array entry reads back as 0.
- R2: A message whose address lies outside [BASE, BASE+SIZE) gets no `req_ack`, starts no reply and leaves the array unchanged. With defaults the window is 3072 to 3135.
- R3: A write (`req_op`=1) inside the window is acknowledged in the next cycle. It stores `req_field` at byte offset `req_addr`-BASE.
- R4: A read (`req_op`=0) inside the window, arriving with no read pending, is acknowledged in the next cycle. `bus_req` first goes high in the third cycle after the message cycle.
- R5: `reply_valid` rises only in the cycle after an edge that saw `bus_req` and `bus_grant` both high. `bus_req` is low while the reply is driven.
- R6: The reply carries the read's `req_field` as `reply_id` and the stored byte as `reply_data`. It stays stable until `reply_ack` is sampled high, and is gone in the following cycle.
- R7: A read inside the window that arrives while a read is pending gets no acknowledgement and produces no reply.
- R8: The reply data is the array value at the edge that accepted the read. A later write to the same address does not alter it.
- R9: A write inside the window is acknowledged and stored even while a read is pending.
- R10: `bus_req` stays high until a grant is sampled. A grant while `bus_req` is low has no effect.
- R11: When `req_valid` is low the address and operation lines are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request message is on the bus this cycle |
| req_addr | input | ADDR_W | Byte address of the message |
| req_op | input | 1 | 0 = read, 1 = write |
| req_field | input | FIELD_W | Requester id for a read, data for a write |
| req_ack | output | 1 | Acknowledge for the message of the previous cycle |
| bus_req | output | 1 | Request to the arbiter to drive a reply |
| bus_grant | input | 1 | Grant from the arbiter |
| reply_valid | output | 1 | Reply message on the bus |
| reply_id | output | FIELD_W | Identifier of the requester being answered |
| reply_data | output | FIELD_W | Value read |
| reply_ack | input | 1 | Requester has copied the reply |

## Verification
Two functions can land on the same edge: taking a write into the array, and handing over or snapshotting a pending read. The bench provokes this in three ways. It issues a write to the address of an outstanding read on the very edge the grant arrives. It issues another write while the reply is held waiting for its acknowledgement. It also sends a second read while the first is still counting its latency. A behavioural model judges each case every cycle: the model keeps its own array and a simple phase counter. The reply must carry the old value, the write must still be acknowledged and stored, and the extra read must vanish without an acknowledgement.

// File: rtl/smt_pkg.sv
package smt_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } smt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ARB   = 2'd2,
    ST_REPLY = 2'd3
  } smt_state_e;

  // Window match on the upper bits only: the address and the base agree above bit SHIFT.
  function automatic logic window_match(input logic [63:0] addr,
                                        input logic [63:0] base,
                                        input int unsigned shift);
    return (addr >> shift) == (base >> shift);
  endfunction

endpackage

// File: rtl/smt_decode.sv
module smt_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BASE   = 3072,
  parameter int unsigned SIZE   = 64,
  localparam int unsigned SHIFT = $clog2(SIZE),
  localparam int unsigned IDX_W = (SHIFT < 1) ? 1 : SHIFT
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  import smt_pkg::*;

  logic [63:0] addr_wide;

  always_comb begin
    addr_wide = 64'(addr);
    hit       = valid && window_match(addr_wide, 64'(BASE), SHIFT);
    idx       = addr[IDX_W-1:0];
  end

endmodule

// File: rtl/smt_store.sv
module smt_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        cells[g] <= wr_data;
    end
  end

  assign rd_data = cells[rd_idx];

endmodule

// File: rtl/smt_reply.sv
module smt_reply #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned RD_LAT  = 2,
  localparam int unsigned CNT_W  = (RD_LAT < 2) ? 1 : $clog2(RD_LAT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [FIELD_W-1:0] acc_id,
  input  logic [FIELD_W-1:0] acc_data,
  input  logic               grant,
  input  logic               rack,
  output logic               idle,
  output logic               want_bus,
  output logic               drive,
  output logic [FIELD_W-1:0] out_id,
  output logic [FIELD_W-1:0] out_data
);
  import smt_pkg::*;

  smt_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FIELD_W-1:0] id_q, data_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_WAIT;
        cnt_d   = CNT_W'(RD_LAT - 1);
      end
      ST_WAIT: if (cnt_q == '0) state_d = ST_ARB;
               else cnt_d = cnt_q - 1'b1;
      ST_ARB:   if (grant) state_d = ST_REPLY;
      ST_REPLY: if (rack)  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      id_q    <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == ST_IDLE && accept) begin
        id_q   <= acc_id;
        data_q <= acc_data;
      end
    end
  end

  assign idle     = (state_q == ST_IDLE);
  assign want_bus = (state_q == ST_ARB);
  assign drive    = (state_q == ST_REPLY);
  assign out_id   = drive ? id_q   : '0;
  assign out_data = drive ? data_q : '0;

endmodule

// File: rtl/split_mem_target.sv
module split_mem_target #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned BASE    = 3072,
  parameter int unsigned SIZE    = 64,
  parameter int unsigned RD_LAT  = 2,
  localparam int unsigned IDX_W  = (SIZE < 2) ? 1 : $clog2(SIZE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_op,
  input  logic [FIELD_W-1:0] req_field,
  output logic               req_ack,
  output logic               bus_req,
  input  logic               bus_grant,
  output logic               reply_valid,
  output logic [FIELD_W-1:0] reply_id,
  output logic [FIELD_W-1:0] reply_data,
  input  logic               reply_ack
);
  import smt_pkg::*;

  // Named internal events, brought out for the checker
  logic               addr_hit;
  logic [IDX_W-1:0]   addr_idx;
  logic               wr_take;
  logic               rd_take;
  logic               rd_idle;
  logic [FIELD_W-1:0] cell_value;
  logic               ack_q;

  smt_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .SIZE(SIZE)) u_decode (
    .valid(req_valid), .addr(req_addr), .hit(addr_hit), .idx(addr_idx)
  );

  assign wr_take = addr_hit && (smt_op_e'(req_op) == OP_WRITE);
  assign rd_take = addr_hit && (smt_op_e'(req_op) == OP_READ) && rd_idle;

  smt_store #(.DEPTH(SIZE), .DATA_W(FIELD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_take), .wr_idx(addr_idx), .wr_data(req_field),
    .rd_idx(addr_idx), .rd_data(cell_value)
  );

  smt_reply #(.FIELD_W(FIELD_W), .RD_LAT(RD_LAT)) u_reply (
    .clk(clk), .rst_n(rst_n),
    .accept(rd_take), .acc_id(req_field), .acc_data(cell_value),
    .grant(bus_grant), .rack(reply_ack),
    .idle(rd_idle), .want_bus(bus_req), .drive(reply_valid),
    .out_id(reply_id), .out_data(reply_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= wr_take || rd_take;
  end

  assign req_ack = ack_q;

endmodule

// File: rtl/smt_chk.sv
module smt_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned FIELD_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_op,
  input logic               req_ack,
  input logic               bus_req,
  input logic               bus_grant,
  input logic               reply_valid,
  input logic [FIELD_W-1:0] reply_id,
  input logic [FIELD_W-1:0] reply_data,
  input logic               reply_ack,
  input logic               addr_hit,
  input logic               rd_idle
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!req_ack && !bus_req && !reply_valid));

  // R2
  ack_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> ($past(req_valid) && $past(addr_hit)));

  // R5
  reply_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && !$past(reply_valid)) |-> $past(bus_req && bus_grant));

  // R5
  req_reply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reply_valid && bus_req));

  // R6
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reply_valid) && !$past(reply_ack)) |->
      (reply_valid && $stable(reply_id) && $stable(reply_data)));

  // R7
  read_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && !$past(req_op)) |-> $past(rd_idle));

  // R10
  req_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_grant) |=> bus_req);

endmodule

bind split_mem_target smt_chk #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_ack(req_ack), .bus_req(bus_req), .bus_grant(bus_grant),
  .reply_valid(reply_valid), .reply_id(reply_id), .reply_data(reply_data),
  .reply_ack(reply_ack), .addr_hit(addr_hit), .rd_idle(rd_idle)
);

// File: tb/tb_split_mem_target.sv
`timescale 1ns/1ps
module tb_split_mem_target;
  localparam int AW = 16, FW = 8, BASE = 3072, SIZE = 64;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_op = 0, bus_grant = 0, reply_ack = 0;
  logic [AW-1:0] req_addr = '0;
  logic [FW-1:0] req_field = '0;
  logic req_ack, bus_req, reply_valid;
  logic [FW-1:0] reply_id, reply_data;

  always #2.5 clk = ~clk;

  split_mem_target dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_field(req_field), .req_ack(req_ack), .bus_req(bus_req),
    .bus_grant(bus_grant), .reply_valid(reply_valid), .reply_id(reply_id),
    .reply_data(reply_data), .reply_ack(reply_ack)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference: phase 0 idle, 1..2 latency, 3 asking, 4 replying
  int m_mem [SIZE];
  int m_phase = 0, m_id = 0, m_data = 0;
  bit e_ack = 0;

  task automatic model_edge();
    bit inwin;
    int off;
    off   = int'(req_addr) - BASE;
    inwin = req_valid && off >= 0 && off < SIZE;
    e_ack = inwin && (req_op || m_phase == 0);
    case (m_phase)
      0: if (inwin && !req_op) begin
           m_id = int'(req_field); m_data = m_mem[off]; m_phase = 1;
         end
      1: m_phase = 2;
      2: m_phase = 3;
      3: if (bus_grant) m_phase = 4;
      4: if (reply_ack) m_phase = 0;
      default: m_phase = 0;
    endcase
    if (inwin && req_op) m_mem[off] = int'(req_field);
  endtask

  task automatic cmp1(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit rv;
    rv = (m_phase == 4);
    cmp1("req_ack", int'(req_ack), int'(e_ack));
    cmp1("bus_req", int'(bus_req), int'(m_phase == 3));
    cmp1("reply_valid", int'(reply_valid), int'(rv));
    if (rv) begin
      cmp1("reply_id", int'(reply_id), m_id);
      cmp1("reply_data", int'(reply_data), m_data);
    end
  endtask

  // One bus cycle: drive at negedge, model at posedge, compare just after
  task automatic cyc(bit v, int addr, bit op, int fld, bit g, bit ra);
    @(negedge clk);
    req_valid = v; req_addr = AW'(addr); req_op = op; req_field = FW'(fld);
    bus_grant = g; reply_ack = ra;
    @(posedge clk);
    if (rst_n) model_edge();
    #1;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < SIZE; i++) m_mem[i] = 0;
    tag = "R1";
    repeat (3) begin
      @(posedge clk); #1;
      cmp1("reset req_ack", int'(req_ack), 0);
      cmp1("reset bus_req", int'(bus_req), 0);
      cmp1("reset reply_valid", int'(reply_valid), 0);
    end
    @(negedge clk); rst_n = 1;
    idle(1);
    // R1: array reads back zero
    cyc(1, BASE + 9, 0, 8'h11, 0, 0); idle(2); cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 1); idle(1);

    tag = "R3";
    cyc(1, BASE, 1, 8'hA5, 0, 0);
    cyc(1, BASE + 5, 1, 8'h3C, 0, 0);
    cyc(1, BASE + 63, 1, 8'hF0, 0, 0);
    idle(1);

    tag = "R2";
    cyc(1, BASE + SIZE, 1, 8'h77, 0, 0);
    cyc(1, BASE - 1, 1, 8'h66, 0, 0);
    cyc(1, BASE - SIZE, 1, 8'h55, 0, 0);
    cyc(1, BASE + SIZE + 5, 0, 8'h44, 0, 0);
    idle(4);

    tag = "R11";
    cyc(0, BASE + 5, 1, 8'h99, 0, 0);
    cyc(0, BASE + 5, 0, 8'h98, 0, 0);
    idle(4);

    tag = "R10";
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);

    tag = "R4";
    cyc(1, BASE, 0, 8'h21, 0, 0);
    idle(3);
    tag = "R10";
    idle(3);
    tag = "R5";
    cyc(0, 0, 0, 0, 1, 0);
    tag = "R6";
    cyc(0, 0, 0, 0, 1, 0);
    idle(3);
    cyc(0, 0, 0, 0, 0, 1);
    idle(2);

    tag = "R7";
    cyc(1, BASE + 5, 0, 8'h31, 0, 0);
    cyc(1, BASE + 63, 0, 8'h32, 0, 0);
    cyc(1, BASE, 0, 8'h33, 0, 0);
    idle(1);
    cyc(1, BASE, 0, 8'h34, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    idle(2);

    tag = "R8";
    cyc(1, BASE + 63, 0, 8'h41, 0, 0);
    tag = "R9";
    cyc(1, BASE + 63, 1, 8'h0F, 0, 0);
    idle(1);
    tag = "R8";
    cyc(1, BASE + 63, 1, 8'hE1, 1, 0);
    cyc(1, BASE + 7, 1, 8'h70, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    idle(1);
    tag = "R9";
    cyc(1, BASE + 63, 0, 8'h42, 0, 0);
    idle(2);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, BASE + 7, 0, 8'h43, 0, 1);
    idle(2);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule